// File: doc/BRIEF.md
# Synchronous Serial Frame Transmitter

This block is a master-side serial transmitter. It takes parallel words through a valid/ready stream and shifts them out one bit per bit slot on a data pin. It also drives the bit clock and a frame-sync line. A frame is a run of bit slots: first a number of lead slots set by two delay fields, then the words of the frame back to back. Mode inputs set the sync style, the sync polarity, the bit order, the word length, the words per frame, which clock edge launches data, and what the data pin does when no data bit is being sent.

The input stream feeds a one-word holding stage. `in_ready` is high only while that stage is empty, so the source sees back-pressure whenever a word is already waiting. A frame starts when the transmitter is enabled and a word is held. Each later word is taken from the stage at the start of its first bit slot. If the stage is empty at that moment, the word is sent as zeros and an underflow pulse is raised. The configuration inputs must stay stable while a frame is running.

Top module: `sfx_tx`

## Requirements
- R1: `in_ready` is high exactly when the one-word holding stage is empty. A word is taken on a rising clock edge that sees `in_valid` and `in_ready` both high. After that edge `in_ready` stays low until the engine consumes the word, so a word presented while the stage is full waits without loss.
- R2: A bit slot lasts 2·(`cfg_psc`+1)·2^`cfg_div` system clocks, split into two equal halves.
- R3: When no frame is running, `sclk_o` rests at the level of `cfg_fall_edge`. Each bit slot opens with the launch edge and the data for that slot: rising when `cfg_fall_edge`=0, falling when 1.
- R4: A word carries `cfg_bits_m1`+1 bits (values below 7 act as 7, so 8 to 32 bits). A frame carries `cfg_words_m1`+1 words (1 to 64). A frame has `cfg_sync_dly`+`cfg_data_dly`+words·bits slots.
- R5: `cfg_lsb_first`=1 sends bit 0 of each word first. With 0, bit (bits−1) goes first.
- R6: Sync style `cfg_sync_mode` (the sync goes active at slot `cfg_sync_dly` in every style): 0 (and 1) marks only that slot. 2 keeps the sync active through the last slot. 3 keeps it active through the lead slots and the first ⌊words/2⌋ words, then inactive for the rest.
- R7: `cfg_sync_low`=1 makes the active sync level 0. With 0 the active level is 1. An inactive sync, including between frames, sits at the opposite level.
- R8: Slot numbers count from 0 at the start of the frame. The sync goes active in slot `cfg_sync_dly`, and the first data bit is sent in slot `cfg_sync_dly`+`cfg_data_dly`.
- R9: Outside data slots (between frames, while disabled, and during lead slots) the data pin follows `cfg_idle_sel`: 0 drives 0, 1 drives 1, 2 or 3 releases the pin (`dout_oe`=0). In data slots `dout_oe`=1.
- R10: `frame_end` is high for exactly one system clock, one full bit slot after the start of the last slot of the frame.
- R11: When a word after the first is due and none is held, that word is sent as all zeros and `underflow` pulses for one clock.
- R12: With `tx_en` low no frame starts, and a running frame stops at the next edge with no `frame_end`. The clock and data pin then go to their idle levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmitter enable |
| cfg_sync_mode | input | 2 | Sync style: 0 pulse, 2 level, 3 left/right |
| cfg_sync_low | input | 1 | Active-low sync when set |
| cfg_lsb_first | input | 1 | LSB first when set |
| cfg_bits_m1 | input | 5 | Bits per word minus one |
| cfg_words_m1 | input | 6 | Words per frame minus one |
| cfg_fall_edge | input | 1 | Launch on falling edge when set |
| cfg_sync_dly | input | 3 | Slots before the sync goes active |
| cfg_data_dly | input | 3 | Slots from sync to the first data bit |
| cfg_idle_sel | input | 2 | Data pin idle state: 0 low, 1 high, 2/3 released |
| cfg_psc | input | 5 | Prescaler minus one |
| cfg_div | input | 3 | Power-of-two divider exponent |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Holding stage empty |
| in_data | input | 32 | Input word |
| sclk_o | output | 1 | Bit clock |
| sync_o | output | 1 | Frame sync |
| dout_o | output | 1 | Serial data |
| dout_oe | output | 1 | Data pin output enable |
| frame_end | output | 1 | One-clock end-of-frame pulse |
| underflow | output | 1 | One-clock pulse when a word was missing |

## Verification
The bench watches the pins slot by slot. At every launch edge it records the sync, data and enable values and compares them with a frame rebuilt from the configuration. A block that mixed up the two delay fields, or let the pulse style fall one slot off when the data delay is zero, would show sync in the wrong slot. A left/right sync that split on the wrong word would show the same. A word-length clamp that passed short sizes through would give a shorter frame, and a reversed bit order would garble every word. Other tests starve the stream in mid-frame, hold a second word against a full stage, and drop the enable in mid-frame. In those tests a faulty design would send stale data instead of zeros, lose the held word, or emit a spurious frame end.

// File: rtl/sfx_pkg.sv
package sfx_pkg;
  localparam int MIN_BITS = 8;

  typedef enum logic [1:0] {
    SYNC_PULSE = 2'd0,
    SYNC_ALT   = 2'd1,
    SYNC_LEVEL = 2'd2,
    SYNC_LR    = 2'd3
  } sync_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } eng_state_e;
endpackage

// File: rtl/sfx_baud.sv
module sfx_baud #(
  parameter int PSC_W = 5,
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] psc,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int HALF_W = PSC_W + (1 << DIV_W);

  logic [HALF_W-1:0] half_len;
  logic [HALF_W-1:0] cnt;

  assign half_len = (HALF_W'(psc) + HALF_W'(1)) << div;
  assign tick     = run && (cnt == half_len - HALF_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + HALF_W'(1);
  end
endmodule

// File: rtl/sfx_hold.sv
module sfx_hold #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              take,
  output logic              in_ready,
  output logic              full,
  output logic [DATA_W-1:0] word
);
  assign in_ready = !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 full <= 1'b0;
    else if (take)              full <= 1'b0;
    else if (in_valid && !full) full <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (in_valid && !full) word <= in_data;
  end
endmodule

// File: rtl/sfx_seq.sv
module sfx_seq import sfx_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int BITS_W = 5,
  parameter int WCNT_W = 6,
  parameter int DLY_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              tick,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_word,
  input  logic [BITS_W-1:0] bits_m1,
  input  logic [WCNT_W-1:0] words_m1,
  input  logic [DLY_W-1:0]  sync_dly,
  input  logic [DLY_W-1:0]  data_dly,
  output logic              running,
  output logic              phase,
  output logic              in_pre,
  output logic [DLY_W:0]    pos,
  output logic [WCNT_W-1:0] word_idx,
  output logic [BITS_W-1:0] bit_idx,
  output logic [DATA_W-1:0] cur_word,
  output logic              take,
  output logic              underflow,
  output logic              frame_end
);
  localparam int POS_W = DLY_W + 1;

  eng_state_e        st, st_d;
  logic              phase_d, pre_d, uf_d, fe_d;
  logic [POS_W-1:0]  pos_d, lead;
  logic [WCNT_W-1:0] word_d;
  logic [BITS_W-1:0] bit_d;
  logic [DATA_W-1:0] cw_d;

  assign lead    = POS_W'(sync_dly) + POS_W'(data_dly);
  assign running = (st == ST_RUN);

  always_comb begin
    st_d    = st;
    phase_d = phase;
    pre_d   = in_pre;
    pos_d   = pos;
    word_d  = word_idx;
    bit_d   = bit_idx;
    cw_d    = cur_word;
    take    = 1'b0;
    uf_d    = 1'b0;
    fe_d    = 1'b0;
    if (st == ST_IDLE) begin
      if (tx_en && hold_full) begin
        st_d    = ST_RUN;
        phase_d = 1'b1;
        pos_d   = '0;
        word_d  = '0;
        bit_d   = '0;
        if (lead == '0) begin
          pre_d = 1'b0;
          cw_d  = hold_word;
          take  = 1'b1;
        end else begin
          pre_d = 1'b1;
        end
      end
    end else if (!tx_en) begin
      st_d = ST_IDLE;
    end else if (tick) begin
      if (phase) begin
        phase_d = 1'b0;
      end else begin
        phase_d = 1'b1;
        if (in_pre && ((pos + POS_W'(1)) < lead)) begin
          pos_d = pos + POS_W'(1);
        end else if (in_pre) begin
          pre_d = 1'b0;
          cw_d  = hold_word;
          take  = 1'b1;
        end else if (bit_idx != bits_m1) begin
          bit_d = bit_idx + BITS_W'(1);
        end else if (word_idx != words_m1) begin
          word_d = word_idx + WCNT_W'(1);
          bit_d  = '0;
          if (hold_full) begin
            cw_d = hold_word;
            take = 1'b1;
          end else begin
            cw_d = '0;
            uf_d = 1'b1;
          end
        end else begin
          st_d = ST_IDLE;
          fe_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      phase     <= 1'b0;
      in_pre    <= 1'b0;
      pos       <= '0;
      word_idx  <= '0;
      bit_idx   <= '0;
      cur_word  <= '0;
      underflow <= 1'b0;
      frame_end <= 1'b0;
    end else begin
      st        <= st_d;
      phase     <= phase_d;
      in_pre    <= pre_d;
      pos       <= pos_d;
      word_idx  <= word_d;
      bit_idx   <= bit_d;
      cur_word  <= cw_d;
      underflow <= uf_d;
      frame_end <= fe_d;
    end
  end
endmodule

// File: rtl/sfx_pins.sv
module sfx_pins import sfx_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int BITS_W = 5,
  parameter int WCNT_W = 6,
  parameter int DLY_W  = 3
) (
  input  logic              running,
  input  logic              phase,
  input  logic              in_pre,
  input  logic [DLY_W:0]    pos,
  input  logic [WCNT_W-1:0] word_idx,
  input  logic [BITS_W-1:0] bit_idx,
  input  logic [DATA_W-1:0] cur_word,
  input  logic [BITS_W-1:0] bits_m1,
  input  logic [WCNT_W-1:0] words_m1,
  input  logic [1:0]        sync_mode,
  input  logic              sync_low,
  input  logic              lsb_first,
  input  logic              fall_edge,
  input  logic [DLY_W-1:0]  sync_dly,
  input  logic [DLY_W-1:0]  data_dly,
  input  logic [1:0]        idle_sel,
  output logic              sclk_o,
  output logic              sync_o,
  output logic              dout_o,
  output logic              dout_oe
);
  logic [WCNT_W:0]   half_words;
  logic [BITS_W-1:0] sel;
  logic              sync_act, data_slot;
  sync_mode_e        mode;

  assign mode       = sync_mode_e'(sync_mode);
  assign half_words = ({1'b0, words_m1} + (WCNT_W+1)'(1)) >> 1;
  assign sel        = lsb_first ? bit_idx : (bits_m1 - bit_idx);
  assign data_slot  = running && !in_pre;

  always_comb begin
    sync_act = 1'b0;
    if (running) begin
      if (in_pre) begin
        if (mode == SYNC_LEVEL || mode == SYNC_LR)
          sync_act = (pos >= (DLY_W+1)'(sync_dly));
        else
          sync_act = (pos == (DLY_W+1)'(sync_dly));
      end else begin
        case (mode)
          SYNC_LEVEL: sync_act = 1'b1;
          SYNC_LR:    sync_act = ({1'b0, word_idx} < half_words);
          default:    sync_act = (data_dly == '0) && (word_idx == '0) && (bit_idx == '0);
        endcase
      end
    end
  end

  assign sync_o  = sync_act ^ sync_low;
  assign sclk_o  = running ? (phase ^ fall_edge) : fall_edge;
  assign dout_oe = data_slot ? 1'b1 : !idle_sel[1];
  assign dout_o  = data_slot ? cur_word[sel] : (idle_sel == 2'd1);
endmodule

// File: rtl/sfx_tx.sv
module sfx_tx import sfx_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int WCNT_W = 6,
  parameter int DLY_W  = 3,
  parameter int PSC_W  = 5,
  parameter int DIV_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tx_en,
  input  logic [1:0]                cfg_sync_mode,
  input  logic                      cfg_sync_low,
  input  logic                      cfg_lsb_first,
  input  logic [$clog2(DATA_W)-1:0] cfg_bits_m1,
  input  logic [WCNT_W-1:0]         cfg_words_m1,
  input  logic                      cfg_fall_edge,
  input  logic [DLY_W-1:0]          cfg_sync_dly,
  input  logic [DLY_W-1:0]          cfg_data_dly,
  input  logic [1:0]                cfg_idle_sel,
  input  logic [PSC_W-1:0]          cfg_psc,
  input  logic [DIV_W-1:0]          cfg_div,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [DATA_W-1:0]         in_data,
  output logic                      sclk_o,
  output logic                      sync_o,
  output logic                      dout_o,
  output logic                      dout_oe,
  output logic                      frame_end,
  output logic                      underflow
);
  localparam int BITS_W = $clog2(DATA_W);
  localparam logic [BITS_W-1:0] FLOOR_M1 = BITS_W'(MIN_BITS - 1);

  logic              tick, running, phase, in_pre, take, hold_full;
  logic [DLY_W:0]    pos;
  logic [WCNT_W-1:0] word_idx;
  logic [BITS_W-1:0] bit_idx, bits_m1;
  logic [DATA_W-1:0] hold_word, cur_word;

  assign bits_m1 = (cfg_bits_m1 < FLOOR_M1) ? FLOOR_M1 : cfg_bits_m1;

  sfx_baud #(.PSC_W(PSC_W), .DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(running),
    .psc(cfg_psc), .div(cfg_div), .tick(tick)
  );

  sfx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .take(take), .in_ready(in_ready), .full(hold_full), .word(hold_word)
  );

  sfx_seq #(.DATA_W(DATA_W), .BITS_W(BITS_W), .WCNT_W(WCNT_W), .DLY_W(DLY_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tick(tick),
    .hold_full(hold_full), .hold_word(hold_word),
    .bits_m1(bits_m1), .words_m1(cfg_words_m1),
    .sync_dly(cfg_sync_dly), .data_dly(cfg_data_dly),
    .running(running), .phase(phase), .in_pre(in_pre), .pos(pos),
    .word_idx(word_idx), .bit_idx(bit_idx), .cur_word(cur_word),
    .take(take), .underflow(underflow), .frame_end(frame_end)
  );

  sfx_pins #(.DATA_W(DATA_W), .BITS_W(BITS_W), .WCNT_W(WCNT_W), .DLY_W(DLY_W)) u_pins (
    .running(running), .phase(phase), .in_pre(in_pre), .pos(pos),
    .word_idx(word_idx), .bit_idx(bit_idx), .cur_word(cur_word),
    .bits_m1(bits_m1), .words_m1(cfg_words_m1),
    .sync_mode(cfg_sync_mode), .sync_low(cfg_sync_low),
    .lsb_first(cfg_lsb_first), .fall_edge(cfg_fall_edge),
    .sync_dly(cfg_sync_dly), .data_dly(cfg_data_dly), .idle_sel(cfg_idle_sel),
    .sclk_o(sclk_o), .sync_o(sync_o), .dout_o(dout_o), .dout_oe(dout_oe)
  );
endmodule

// File: rtl/sfx_tx_chk.sv
module sfx_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_en,
  input logic       cfg_fall_edge,
  input logic       cfg_sync_low,
  input logic [1:0] cfg_idle_sel,
  input logic       in_valid,
  input logic       in_ready,
  input logic       sclk_o,
  input logic       sync_o,
  input logic       dout_o,
  input logic       dout_oe,
  input logic       frame_end,
  input logic       underflow
);
  a_r1_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  a_r10_end_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !frame_end);

  a_r7_sync_idle_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> (sync_o == cfg_sync_low));

  a_r11_underflow_single: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> !underflow);

  a_r12_clock_parks: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (sclk_o == cfg_fall_edge));

  a_r9_pin_idles: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> ((dout_oe == !cfg_idle_sel[1]) && (!dout_oe || (dout_o == cfg_idle_sel[0]))));
endmodule

bind sfx_tx sfx_tx_chk u_chk (.*);

// File: tb/sfx_tx_tb.sv
`timescale 1ns/1ps
module sfx_tx_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        tx_en = 1'b0;
  logic [1:0]  cfg_sync_mode = '0;
  logic        cfg_sync_low = 1'b0;
  logic        cfg_lsb_first = 1'b0;
  logic [4:0]  cfg_bits_m1 = 5'd7;
  logic [5:0]  cfg_words_m1 = '0;
  logic        cfg_fall_edge = 1'b0;
  logic [2:0]  cfg_sync_dly = '0;
  logic [2:0]  cfg_data_dly = '0;
  logic [1:0]  cfg_idle_sel = '0;
  logic [4:0]  cfg_psc = '0;
  logic [2:0]  cfg_div = '0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready, sclk_o, sync_o, dout_o, dout_oe, frame_end, underflow;

  sfx_tx u_dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en),
    .cfg_sync_mode(cfg_sync_mode), .cfg_sync_low(cfg_sync_low),
    .cfg_lsb_first(cfg_lsb_first), .cfg_bits_m1(cfg_bits_m1),
    .cfg_words_m1(cfg_words_m1), .cfg_fall_edge(cfg_fall_edge),
    .cfg_sync_dly(cfg_sync_dly), .cfg_data_dly(cfg_data_dly),
    .cfg_idle_sel(cfg_idle_sel), .cfg_psc(cfg_psc), .cfg_div(cfg_div),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .sclk_o(sclk_o), .sync_o(sync_o), .dout_o(dout_o), .dout_oe(dout_oe),
    .frame_end(frame_end), .underflow(underflow)
  );

  int vecs = 0;
  int errs = 0;
  int cyc  = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [31:0] exp_words [0:63];
  logic        cap_sync [0:4095];
  logic        cap_dout [0:4095];
  logic        cap_oe   [0:4095];
  int          cap_t    [0:4095];
  int          ncap, nunder, end_t;
  bit          got_end, end_one;

  task automatic check(string req, string what, longint act, longint exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(int mode, bit slow, bit lsb, int bm1, int wm1, bit fall,
                         int sd, int dd, int idle, int psc, int dv);
    cfg_sync_mode = 2'(mode); cfg_sync_low = slow; cfg_lsb_first = lsb;
    cfg_bits_m1 = 5'(bm1); cfg_words_m1 = 6'(wm1); cfg_fall_edge = fall;
    cfg_sync_dly = 3'(sd); cfg_data_dly = 3'(dd); cfg_idle_sel = 2'(idle);
    cfg_psc = 5'(psc); cfg_div = 3'(dv);
  endtask

  task automatic make_words(logic [31:0] seed);
    for (int i = 0; i < 64; i++)
      exp_words[i] = (32'hA5C3_0F00 + 32'(i) * 32'h0135_7B9D) ^ seed;
  endtask

  task automatic feed(int first, int last);
    for (int i = first; i < last; i++) begin
      in_data  = exp_words[i];
      in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic capture(int limit);
    logic prev;
    ncap = 0; nunder = 0; got_end = 0; end_one = 0;
    prev = sclk_o;
    for (int i = 0; i < limit && !got_end; i++) begin
      @(negedge clk);
      if (prev == cfg_fall_edge && sclk_o != cfg_fall_edge && ncap < 4096) begin
        cap_sync[ncap] = sync_o; cap_dout[ncap] = dout_o;
        cap_oe[ncap] = dout_oe;  cap_t[ncap] = cyc;
        ncap++;
      end
      prev = sclk_o;
      if (underflow) nunder++;
      if (frame_end) begin got_end = 1; end_t = cyc; end
    end
    if (got_end) begin
      @(negedge clk);
      end_one = !frame_end;
    end
  endtask

  task automatic run_frame(int first, int last, int limit);
    fork
      feed(first, last);
      capture(limit);
    join
  endtask

  task automatic compare(string rq_sync, string rq_data, int n_sup);
    int bits, words, sd, L, S, half, ms, md, w, b, bi;
    bit act, esync, eoe, ed;
    logic [31:0] wd;
    bits  = (cfg_bits_m1 < 7) ? 8 : int'(cfg_bits_m1) + 1;
    words = int'(cfg_words_m1) + 1;
    sd    = int'(cfg_sync_dly);
    L     = sd + int'(cfg_data_dly);
    S     = L + words * bits;
    half  = (int'(cfg_psc) + 1) << cfg_div;
    ms = 0; md = 0;
    check("R4", "slot count", ncap, S);
    for (int k = 0; k < ncap && k < S; k++) begin
      if (cfg_sync_mode == 2'd2)      act = (k >= sd);
      else if (cfg_sync_mode == 2'd3) act = (k >= sd) && (k < L || ((k - L) / bits) < (words / 2));
      else                            act = (k == sd);
      esync = act ^ cfg_sync_low;
      if (k < L) begin
        eoe = (cfg_idle_sel < 2);
        ed  = (cfg_idle_sel == 2'd1);
      end else begin
        w  = (k - L) / bits;
        b  = (k - L) % bits;
        wd = (w < n_sup) ? exp_words[w] : 32'd0;
        bi = cfg_lsb_first ? b : bits - 1 - b;
        ed = wd[bi];
        eoe = 1'b1;
      end
      if (cap_sync[k] != esync) ms++;
      if (cap_oe[k] != eoe || (eoe && cap_dout[k] != ed)) md++;
    end
    check(rq_sync, "sync slot mismatches", ms, 0);
    check(rq_data, "data slot mismatches", md, 0);
    check("R10", "frame end seen", got_end, 1);
    check("R10", "frame end one clock", end_one, 1);
    if (ncap == S && got_end)
      check("R10", "frame end delay", end_t - cap_t[S-1], 2 * half);
    check("R11", "underflow pulses", nunder, (n_sup < words) ? words - n_sup : 0);
  endtask

  task automatic t_reset();
    check("R3", "sclk idle after reset", sclk_o, 0);
    check("R7", "sync idle after reset", sync_o, 0);
    check("R9", "oe idle after reset", dout_oe, 1);
    check("R9", "dout idle after reset", dout_o, 0);
    check("R1", "ready after reset", in_ready, 1);
    check("R10", "no frame end after reset", frame_end, 0);
  endtask

  task automatic t_level_msb();
    set_cfg(2, 0, 0, 7, 1, 0, 0, 0, 0, 0, 0);
    make_words(32'h0000_0000);
    tx_en = 1'b1;
    run_frame(0, 2, 200);
    compare("R6", "R4", 2);
  endtask

  task automatic t_pulse_lsb_low();
    set_cfg(0, 1, 1, 11, 0, 1, 2, 3, 1, 0, 0);
    make_words(32'h1234_5678);
    run_frame(0, 1, 200);
    compare("R7", "R5", 1);
    check("R8", "pulse frame slots", ncap, 17);
  endtask

  task automatic t_lr_hiz();
    set_cfg(3, 0, 0, 15, 3, 0, 1, 0, 2, 0, 0);
    make_words(32'hDEAD_BEEF);
    run_frame(0, 4, 400);
    compare("R6", "R9", 4);
  endtask

  task automatic t_clamp_pulse();
    set_cfg(0, 0, 0, 3, 2, 1, 3, 0, 3, 0, 0);
    make_words(32'h0F0F_3C3C);
    run_frame(0, 3, 300);
    compare("R8", "R4", 3);
  endtask

  task automatic t_max_frame();
    set_cfg(2, 0, 1, 31, 63, 0, 0, 0, 0, 0, 0);
    make_words(32'h5555_AAAA);
    run_frame(0, 64, 5000);
    compare("R6", "R4", 64);
  endtask

  task automatic t_underflow();
    set_cfg(2, 0, 0, 7, 2, 0, 0, 1, 1, 0, 0);
    make_words(32'hFFFF_FFFF);
    run_frame(0, 1, 300);
    compare("R6", "R11", 1);
  endtask

  task automatic t_baud();
    set_cfg(2, 0, 0, 7, 0, 0, 0, 0, 0, 2, 2);
    make_words(32'h0BAD_F00D);
    run_frame(0, 1, 400);
    compare("R6", "R2", 1);
    if (ncap > 1) check("R2", "bit period", cap_t[1] - cap_t[0], 24);
  endtask

  task automatic t_backpressure();
    set_cfg(2, 0, 0, 7, 1, 0, 0, 0, 0, 0, 0);
    make_words(32'h3C5A_9600);
    tx_en = 1'b0;
    @(negedge clk);
    in_data = exp_words[0]; in_valid = 1'b1;
    @(negedge clk);
    check("R1", "ready drops when full", in_ready, 0);
    in_data = exp_words[1];
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R1", "ready stays low", in_ready, 0);
      check("R12", "clock parked while disabled", sclk_o, 0);
    end
    check("R9", "idle low drives 0", {dout_oe, dout_o}, 2'b10);
    cfg_idle_sel = 2'd1; #1;
    check("R9", "idle high drives 1", {dout_oe, dout_o}, 2'b11);
    cfg_idle_sel = 2'd2; #1;
    check("R9", "idle release", dout_oe, 0);
    cfg_idle_sel = 2'd0;
    @(negedge clk);
    tx_en = 1'b1;
    run_frame(1, 2, 200);
    compare("R6", "R1", 2);
  endtask

  task automatic t_abort();
    bit seen_end, clk_moved;
    set_cfg(2, 0, 0, 31, 0, 1, 0, 0, 1, 0, 0);
    make_words(32'h7777_1111);
    tx_en = 1'b1;
    fork
      feed(0, 1);
      repeat (20) @(negedge clk);
    join
    tx_en = 1'b0;
    seen_end = 0; clk_moved = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (frame_end) seen_end = 1;
      if (sclk_o != 1'b1) clk_moved = 1;
    end
    check("R12", "no frame end after abort", seen_end, 0);
    check("R12", "clock parked after abort", clk_moved, 0);
    check("R9", "pin idle after abort", {dout_oe, dout_o}, 2'b11);
    check("R1", "stage empty after abort", in_ready, 1);
    tx_en = 1'b1;
    clk_moved = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (sclk_o != 1'b1) clk_moved = 1;
    end
    check("R12", "no frame without a word", clk_moved, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    vecs++; errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_level_msb();
    repeat (3) @(negedge clk);
    t_pulse_lsb_low();
    repeat (3) @(negedge clk);
    t_lr_hiz();
    repeat (3) @(negedge clk);
    t_clamp_pulse();
    repeat (3) @(negedge clk);
    t_max_frame();
    repeat (3) @(negedge clk);
    t_underflow();
    repeat (3) @(negedge clk);
    t_baud();
    repeat (3) @(negedge clk);
    t_backpressure();
    repeat (3) @(negedge clk);
    t_abort();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule